// File: doc/BRIEF.md
# Masked Alarm Latch Interrupt Controller

This block collects sixteen live condition flags into one raw status word, filters them through an enable mask that the host can rewrite at any time, and records every masked low-to-high transition in a sticky alarm register. A single interrupt line reports whether any recorded alarm is still pending. Two condition bits report scan completion. Once the first scan is done, their live flags stay high. They are special-cased: a scan-complete event pulse records them again every time a scan finishes.

The host reaches the block through a small word-wide register port with a combinational read path. Three addresses are decoded: the live raw word, the sticky alarm word and the enable mask. The sticky word is cleared per bit by writing ones. Bits written as zero are untouched. A pending bit cannot be lost to a clear that overlaps with a new event. The interrupt can be routed to an external pin. A two-bit pin-function field selects the alarm function, and a two-bit style field selects one of three drive styles. The pin is presented as a drive value plus an output enable.

Top module: `alarm_latch_ctrl`

## Requirements
- R1: Reading address 0x64 returns the present raw word: bit n equals status_flags[n] for every bit except 8, 11 and 12, which ignore status_flags.
- R2: Raw bit 12 is 1 when any bit of sf_alert AND sf_alert_mask is 1. Raw bit 11 is 1 when any bit of pf_alert AND pf_alert_mask is 1.
- R3: Writing address 0x66 loads the enable mask from reg_wdata one cycle later, and reading 0x66 returns it. A write to 0x64 changes nothing.
- R4: Sticky bit n (read at 0x62) becomes 1 the cycle after raw bit n rises while mask bit n is 1. With mask bit n at 0, a rise leaves it at 0.
- R5: Sticky bit 1 becomes 1 after each scan_evt pulse, and sticky bit 7 after each full_scan_evt pulse, whenever the matching mask bit is 1, even though their raw flags stay high.
- R6: A write to 0x62 clears exactly the sticky bits written as 1. Bits written as 0 keep their value.
- R7: When a set condition and a clear write hit the same sticky bit in the same cycle, the bit ends up 1.
- R8: irq is 1 exactly when the sticky word is nonzero.
- R9: Bit 8 reads 0 in the raw and sticky words and never latches.
- R10: After reset the sticky word, the mask and the edge history are 0, irq is 0 and pin_oe is 0.
- R11: When pin_func is not 2'b10, pin_oe and pin_out are 0.
- R12: When pin_func is 2'b10, the drive_style codes behave as follows. Code 1 gives oe=1 and out=irq. Code 2 gives oe=1 and out=!irq. Codes 0 and 3 give oe=irq and out=0, which is active low with hi-Z when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| status_flags | input | 16 | Live condition flags |
| sf_alert | input | SF_W | Safety alert flags |
| sf_alert_mask | input | SF_W | Per-flag mask for safety alerts |
| pf_alert | input | PF_W | Permanent-fail alert flags |
| pf_alert_mask | input | PF_W | Per-flag mask for permanent-fail alerts |
| scan_evt | input | 1 | One-cycle pulse: a single scan finished |
| full_scan_evt | input | 1 | One-cycle pulse: a full scan loop finished |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| pin_func | input | 2 | Pin function select; 2'b10 selects the alarm |
| drive_style | input | 2 | Pin drive style code |
| irq | output | 1 | OR of all sticky bits |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin output enable |

## Verification
A new set condition and a host clear can land on the same sticky bit in the same cycle. The bench provokes this by raising a flag, or pulsing a scan event, in the very cycle that a clear write names that bit. It judges the result by reading the sticky word afterwards: the bit must still be 1 while the other named bits are gone. A second overlap is a mask write made while a flag rises. The bench orders these events through its own cycle model and compares each register read against it.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int STAT_W       = 16;
  localparam int BIT_ADSCAN   = 1;
  localparam int BIT_FULLSCAN = 7;
  localparam int BIT_RSVD     = 8;
  localparam int BIT_PFALERT  = 11;
  localparam int BIT_SFALERT  = 12;

  localparam logic [7:0] ADDR_STAT = 8'h62;
  localparam logic [7:0] ADDR_RAW  = 8'h64;
  localparam logic [7:0] ADDR_MASK = 8'h66;

  localparam logic [1:0] PINF_ALARM = 2'b10;

  typedef enum logic [1:0] {
    DRV_LOW_HIZ = 2'd0,
    DRV_HIGH_PP = 2'd1,
    DRV_LOW_PP  = 2'd2,
    DRV_SPARE   = 2'd3
  } drv_style_e;
endpackage

// File: rtl/alarm_raw_gather.sv
module alarm_raw_gather
  import alarm_pkg::*;
#(
  parameter int SF_W = 8,
  parameter int PF_W = 8
) (
  input  logic [STAT_W-1:0] flags_i,
  input  logic [SF_W-1:0]   sf_alert_i,
  input  logic [SF_W-1:0]   sf_mask_i,
  input  logic [PF_W-1:0]   pf_alert_i,
  input  logic [PF_W-1:0]   pf_mask_i,
  output logic [STAT_W-1:0] raw_o
);
  localparam logic [STAT_W-1:0] OVERRIDE =
    (STAT_W'(1) << BIT_RSVD) | (STAT_W'(1) << BIT_PFALERT) | (STAT_W'(1) << BIT_SFALERT);

  logic sf_any, pf_any;

  assign sf_any = |(sf_alert_i & sf_mask_i);
  assign pf_any = |(pf_alert_i & pf_mask_i);

  always_comb begin
    raw_o              = flags_i & ~OVERRIDE;
    raw_o[BIT_SFALERT] = sf_any;
    raw_o[BIT_PFALERT] = pf_any;
  end
endmodule

// File: rtl/alarm_latch_bank.sv
module alarm_latch_bank
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] raw_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              scan_evt_i,
  input  logic              full_evt_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] prev_o
);
  logic [STAT_W-1:0] prev_q, prev_d;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [STAT_W-1:0] set_v;

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b == BIT_RSVD) begin : g_rsvd
      assign set_v[b] = 1'b0;
    end else if (b == BIT_ADSCAN) begin : g_scan
      assign set_v[b] = mask_i[b] & ((raw_i[b] & ~prev_q[b]) | scan_evt_i);
    end else if (b == BIT_FULLSCAN) begin : g_full
      assign set_v[b] = mask_i[b] & ((raw_i[b] & ~prev_q[b]) | full_evt_i);
    end else begin : g_plain
      assign set_v[b] = mask_i[b] & raw_i[b] & ~prev_q[b];
    end
  end

  always_comb begin
    prev_d = raw_i;
    stat_d = (stat_q & ~clr_i) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= prev_d;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/alarm_pin_drive.sv
module alarm_pin_drive
  import alarm_pkg::*;
(
  input  logic       active_i,
  input  logic [1:0] pin_func_i,
  input  logic [1:0] style_i,
  output logic       pin_out_o,
  output logic       pin_oe_o
);
  always_comb begin
    pin_out_o = 1'b0;
    pin_oe_o  = 1'b0;
    if (pin_func_i == PINF_ALARM) begin
      case (drv_style_e'(style_i))
        DRV_HIGH_PP: begin
          pin_oe_o  = 1'b1;
          pin_out_o = active_i;
        end
        DRV_LOW_PP: begin
          pin_oe_o  = 1'b1;
          pin_out_o = ~active_i;
        end
        default: begin
          pin_oe_o  = active_i;
          pin_out_o = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/alarm_latch_ctrl.sv
module alarm_latch_ctrl
  import alarm_pkg::*;
#(
  parameter int               SF_W     = 8,
  parameter int               PF_W     = 8,
  parameter int               ADDR_W   = 8,
  parameter logic [STAT_W-1:0] MASK_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_flags,
  input  logic [SF_W-1:0]   sf_alert,
  input  logic [SF_W-1:0]   sf_alert_mask,
  input  logic [PF_W-1:0]   pf_alert,
  input  logic [PF_W-1:0]   pf_alert_mask,
  input  logic              scan_evt,
  input  logic              full_scan_evt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  input  logic [1:0]        pin_func,
  input  logic [1:0]        drive_style,
  output logic              irq,
  output logic              pin_out,
  output logic              pin_oe
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(ADDR_RAW);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);

  logic [1:0]        rst_sync_q;
  logic              rst_q_n;
  logic [STAT_W-1:0] raw, prev, stat;
  logic [STAT_W-1:0] mask_q, mask_d;
  logic [STAT_W-1:0] clr_v;
  logic              wr_stat, wr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_mask = reg_wr && (reg_addr == A_MASK);

  always_comb begin
    clr_v  = wr_stat ? reg_wdata : '0;
    mask_d = wr_mask ? reg_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) mask_q <= MASK_RST;
    else          mask_q <= mask_d;
  end

  alarm_raw_gather #(.SF_W(SF_W), .PF_W(PF_W)) u_gather (
    .flags_i    (status_flags),
    .sf_alert_i (sf_alert),
    .sf_mask_i  (sf_alert_mask),
    .pf_alert_i (pf_alert),
    .pf_mask_i  (pf_alert_mask),
    .raw_o      (raw)
  );

  alarm_latch_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .raw_i      (raw),
    .mask_i     (mask_q),
    .scan_evt_i (scan_evt),
    .full_evt_i (full_scan_evt),
    .clr_i      (clr_v),
    .stat_o     (stat),
    .prev_o     (prev)
  );

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = stat;
      A_RAW:   reg_rdata = raw;
      A_MASK:  reg_rdata = mask_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |stat;

  alarm_pin_drive u_pin (
    .active_i   (irq),
    .pin_func_i (pin_func),
    .style_i    (drive_style),
    .pin_out_o  (pin_out),
    .pin_oe_o   (pin_oe)
  );
endmodule

// File: rtl/alarm_latch_chk.sv
module alarm_latch_chk
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [STAT_W-1:0] reg_wdata,
  input logic [STAT_W-1:0] reg_rdata,
  input logic              scan_evt,
  input logic              full_scan_evt,
  input logic [STAT_W-1:0] raw,
  input logic [STAT_W-1:0] prev,
  input logic [STAT_W-1:0] mask,
  input logic [STAT_W-1:0] stat,
  input logic              irq,
  input logic [1:0]        pin_func,
  input logic [1:0]        drive_style,
  input logic              pin_out,
  input logic              pin_oe
);
  logic [STAT_W-1:0] edge_v, clr_v;

  assign edge_v = raw & ~prev & mask;
  assign clr_v  = (reg_wr && reg_addr == ADDR_W'(ADDR_STAT)) ? reg_wdata : '0;

  p_edge_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(edge_v)) == $past(edge_v)));

  p_scan_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_evt && mask[BIT_ADSCAN]) |=> stat[BIT_ADSCAN]);

  p_full_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_scan_evt && mask[BIT_FULLSCAN]) |=> stat[BIT_FULLSCAN]);

  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat & ~clr_v) & ~stat) == '0));

  p_irq_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(ADDR_STAT)) |-> (irq == (|reg_rdata)));

  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat[BIT_RSVD] && !raw[BIT_RSVD]);

  p_pin_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_func != PINF_ALARM) |-> (!pin_oe && !pin_out));

  p_open_drain_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_func == PINF_ALARM && drive_style == 2'd0) |-> (!pin_out && (pin_oe == irq)));
endmodule

bind alarm_latch_ctrl alarm_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .scan_evt      (scan_evt),
  .full_scan_evt (full_scan_evt),
  .raw           (raw),
  .prev          (prev),
  .mask          (mask_q),
  .stat          (stat),
  .irq           (irq),
  .pin_func      (pin_func),
  .drive_style   (drive_style),
  .pin_out       (pin_out),
  .pin_oe        (pin_oe)
);

// File: tb/tb_alarm_latch_ctrl.sv
module tb_alarm_latch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] status_flags;
  logic [7:0]  sf_alert, sf_alert_mask, pf_alert, pf_alert_mask;
  logic        scan_evt, full_scan_evt;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [1:0]  pin_func, drive_style;
  logic        irq, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_stat, m_prev, m_mask;

  always #4 clk = ~clk;

  alarm_latch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .status_flags(status_flags),
    .sf_alert(sf_alert), .sf_alert_mask(sf_alert_mask),
    .pf_alert(pf_alert), .pf_alert_mask(pf_alert_mask),
    .scan_evt(scan_evt), .full_scan_evt(full_scan_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_func(pin_func), .drive_style(drive_style),
    .irq(irq), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [15:0] exp_raw();
    logic [15:0] r;
    r = status_flags & ~16'h1900;
    r[12] = |(sf_alert & sf_alert_mask);
    r[11] = |(pf_alert & pf_alert_mask);
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    logic [15:0] raw, set, clr;
    @(posedge clk);
    raw = exp_raw();
    set = raw & ~m_prev & m_mask;
    if (scan_evt)      set[1] = set[1] | m_mask[1];
    if (full_scan_evt) set[7] = set[7] | m_mask[7];
    set[8] = 1'b0;
    clr = (reg_wr && reg_addr == 8'h62) ? reg_wdata : 16'h0;
    m_stat = (m_stat & ~clr) | set;
    m_prev = raw;
    if (reg_wr && reg_addr == 8'h66) m_mask = reg_wdata;
    #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string req, input string what);
    reg_addr = a;
    #1;
    chk(req, what, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; status_flags = '0; sf_alert = '0; sf_alert_mask = '0;
    pf_alert = '0; pf_alert_mask = '0; scan_evt = 1'b0; full_scan_evt = 1'b0;
    reg_wr = 1'b0; reg_addr = 8'h62; reg_wdata = '0; pin_func = 2'b10; drive_style = 2'd0;
    m_stat = '0; m_prev = '0; m_mask = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;

    // R10: reset state
    rd_chk(8'h62, 16'h0, "R10", "sticky after reset");
    rd_chk(8'h66, 16'h0, "R10", "mask after reset");
    chk("R10", "irq after reset", irq, 0);
    chk("R10", "pin_oe after reset", pin_oe, 0);

    // R3: mask write/readback, write to raw address ignored
    wr(8'h66, 16'hA5C3);
    rd_chk(8'h66, 16'hA5C3, "R3", "mask readback");
    status_flags = 16'h0011;
    wr(8'h64, 16'hFFFF);
    rd_chk(8'h64, 16'h0011, "R3", "raw after write attempt");
    rd_chk(8'h66, 16'hA5C3, "R3", "mask after raw write");
    status_flags = '0; tick();

    // R1, R4: sweep each bit with mask fully on
    wr(8'h66, 16'hFFFF);
    wr(8'h62, 16'hFFFF);
    for (int b = 0; b < 16; b++) begin
      status_flags = '0; tick();
      wr(8'h62, 16'hFFFF);
      rd_chk(8'h62, 16'h0, "R6", "cleared before sweep");
      status_flags = 16'(1) << b;
      rd_chk(8'h64, (b == 8 || b == 11 || b == 12) ? 16'h0 : (16'(1) << b), "R1", "raw one-hot");
      tick();
      rd_chk(8'h62, (b == 8 || b == 11 || b == 12) ? 16'h0 : (16'(1) << b), "R4", "latched one-hot");
      chk("R8", "irq follows sticky", irq, (b == 8 || b == 11 || b == 12) ? 0 : 1);
      tick();
      rd_chk(8'h62, m_stat, "R4", "sticky holds while flag high");
    end

    // R4: mask off, no latch
    status_flags = '0; tick();
    wr(8'h62, 16'hFFFF);
    wr(8'h66, 16'h0000);
    for (int b = 0; b < 16; b++) begin
      status_flags = '0; tick();
      status_flags = 16'(1) << b; tick(); tick();
      rd_chk(8'h62, 16'h0, "R4", "masked-off rise");
    end
    chk("R8", "irq idle", irq, 0);

    // R2: alert aggregation, near-exhaustive over alert bits
    status_flags = '0;
    wr(8'h66, 16'hFFFF);
    for (int i = 0; i < 8; i++) begin
      sf_alert = 8'(1) << i; sf_alert_mask = ~(8'(1) << i);
      pf_alert = 8'(1) << i; pf_alert_mask = ~(8'(1) << i);
      rd_chk(8'h64, 16'h0, "R2", "alerts masked out");
      tick();
      sf_alert_mask = 8'(1) << i;
      rd_chk(8'h64, 16'h1000, "R2", "safety alert bit");
      pf_alert_mask = 8'(1) << i;
      rd_chk(8'h64, 16'h1800, "R2", "both alert bits");
      tick();
      rd_chk(8'h62, 16'h1800, "R2", "alert bits latched");
      sf_alert = '0; pf_alert = '0; tick();
      wr(8'h62, 16'h1800);
      rd_chk(8'h62, 16'h0, "R6", "alert bits cleared");
    end

    // R5: scan exceptions
    status_flags = 16'h0082; tick(); tick();
    wr(8'h62, 16'hFFFF);
    rd_chk(8'h62, 16'h0, "R5", "no latch while flags stay high");
    for (int k = 0; k < 3; k++) begin
      scan_evt = 1'b1; tick(); scan_evt = 1'b0;
      rd_chk(8'h62, 16'h0002, "R5", "scan event latches bit1");
      wr(8'h62, 16'h0002);
      full_scan_evt = 1'b1; tick(); full_scan_evt = 1'b0;
      rd_chk(8'h62, 16'h0080, "R5", "full scan event latches bit7");
      wr(8'h62, 16'h0080);
    end
    wr(8'h66, 16'hFF7D);
    scan_evt = 1'b1; full_scan_evt = 1'b1; tick(); scan_evt = 1'b0; full_scan_evt = 1'b0;
    rd_chk(8'h62, 16'h0, "R5", "scan events with mask off");
    // R7: scan event during clear of bit 1
    wr(8'h66, 16'hFFFF);
    scan_evt = 1'b1; wr(8'h62, 16'h0002); scan_evt = 1'b0;
    rd_chk(8'h62, 16'h0002, "R7", "scan event wins over clear");
    wr(8'h62, 16'hFFFF);
    status_flags = '0; tick();

    // R6: partial clear
    status_flags = 16'h000D; tick();
    rd_chk(8'h62, 16'h000D, "R6", "setup sticky");
    wr(8'h62, 16'h0004);
    rd_chk(8'h62, 16'h0009, "R6", "one bit cleared");
    wr(8'h62, 16'h0000);
    rd_chk(8'h62, 16'h0009, "R6", "zero write keeps bits");

    // R7: rising flag and clear in same cycle
    status_flags = 16'h002D;
    wr(8'h62, 16'h0021);
    rd_chk(8'h62, 16'h0028, "R7", "set wins, other named bit cleared");
    chk("R7", "model agrees", m_stat, 16'h0028);

    // R3 with R4: mask write concurrent with rise, new mask applies next cycle
    status_flags = '0; tick();
    wr(8'h62, 16'hFFFF);
    wr(8'h66, 16'h0000);
    status_flags = 16'h0040;
    wr(8'h66, 16'h0040);
    rd_chk(8'h62, 16'h0000, "R3", "old mask used in write cycle");
    status_flags = '0; tick();
    status_flags = 16'h0040; tick();
    rd_chk(8'h62, 16'h0040, "R3", "new mask in effect");

    // R9: reserved bit
    wr(8'h66, 16'hFFFF);
    status_flags = '0; tick();
    wr(8'h62, 16'hFFFF);
    status_flags = 16'h0100; tick(); tick();
    rd_chk(8'h64, 16'h0000, "R9", "raw bit8");
    rd_chk(8'h62, 16'h0000, "R9", "sticky bit8");
    status_flags = '0; tick();

    // R11, R12: pin drive sweep for irq 0 and 1
    for (int a = 0; a < 2; a++) begin
      if (a == 1) begin
        status_flags = 16'h0001; tick();
      end else begin
        wr(8'h62, 16'hFFFF);
      end
      chk("R8", "irq level", irq, a);
      for (int f = 0; f < 4; f++) begin
        for (int s = 0; s < 4; s++) begin
          logic eo, eout;
          pin_func = 2'(f); drive_style = 2'(s);
          #1;
          if (f != 2)      begin eo = 0; eout = 0; end
          else if (s == 1) begin eo = 1; eout = a[0]; end
          else if (s == 2) begin eo = 1; eout = ~a[0]; end
          else             begin eo = a[0]; eout = 0; end
          chk((f != 2) ? "R11" : "R12", "pin_oe", pin_oe, eo);
          chk((f != 2) ? "R11" : "R12", "pin_out", pin_out, eout);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule